// File: doc/BRIEF.md
# PSRAM Refresh and Low-Region Chip-Select Sequencer

This block sequences bus cycles for a pseudo-static RAM placed in the low-memory chip-select region. It decodes each processor bus request and drives the low-region chip select and a second select line shared with the mid-range select number three. It counts wait states and honours or ignores an external ready. When PSRAM mode is on, it also runs an interval timer that starts auto-refresh cycles. The memory needs no row address for these cycles. The refresh strobe takes over the shared select pin, and a precharge gap follows every PSRAM access and every refresh.

Software sets the block up through a small write port with two words. The first is the low-region control word: the enable bit, the wait-state count and the ready-ignore flag. The second is the refresh interval reload. A refresh that falls due never cuts into a bus cycle already running. A processor request that arrives while a refresh is running is held off by keeping ready low. When PSRAM mode is off, the timer does nothing and the shared pin is an ordinary chip select.

Top module: `psram_refresh_ctl`

## Requirements
- R1: After reset, PSRAM mode is off, `lcs_n` and `rfsh_cs3_n` are high, `bus_ready` and `precharge` are low, and no refresh strobe appears.
- R2: Writing `cfg_sel`=0 stores the control word. Bits [2:1] are the wait-state count W and bit 3 is the ready-ignore flag; both are always stored. Bit 0 (enable) is stored as 1 only when bits [3:0] equal 4'b1011, which means ready ignored and exactly one wait state. Any other value leaves PSRAM mode off.
- R3: Writing `cfg_sel`=1 loads the refresh reload value from `cfg_wdata`. A value below 18 is ignored and the previous reload is kept.
- R4: With PSRAM mode on and no bus traffic, the first refresh strobe starts exactly reload cycles after the clock edge that enabled the mode. Later strobes start exactly reload cycles apart, because the timer reloads when each refresh is issued.
- R5: A refresh holds `rfsh_cs3_n` low for W+2 cycles. `lcs_n` stays high for the whole refresh, and `precharge` is high for the 2 cycles that follow it.
- R6: A request sampled on a clock edge with the sequencer idle drives its chip select low from the next cycle. The select stays low for W+2 cycles, plus D cycles when ready is not ignored and `ext_ready` first arrives D cycles late. `bus_ready` is high only in the last of those cycles.
- R7: With PSRAM mode on, a low-region access (address below 0x4000) is followed by 2 cycles with `precharge` high and both selects high. With PSRAM mode off, or for other regions, no precharge cycle occurs.
- R8: With PSRAM mode off, an access to the mid-range region three (0x8000 to 0x9FFF) drives `rfsh_cs3_n` low with the timing of R6. Accesses to other addresses leave it high.
- R9: With PSRAM mode on, `rfsh_cs3_n` is low only during refresh. A mid-range region three access still completes with `bus_ready`, but it leaves the pin high.
- R10: A refresh that falls due during a bus cycle or its precharge waits until the sequencer is idle, and it starts on the next edge. A request that arrives during a refresh keeps `bus_ready` low and its select high until the refresh and its precharge end. When a refresh and a request are both ready in the idle state, the refresh goes first.
- R11: With PSRAM mode off, the interval timer is idle and no refresh strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: control word, 1: refresh reload |
| cfg_wdata | input | CNT_W | Configuration write data |
| bus_req | input | 1 | Processor bus cycle request, held until `bus_ready` |
| bus_addr | input | ADDR_W | Address of the requested cycle |
| ext_ready | input | 1 | External ready, used when ready is not ignored |
| lcs_n | output | 1 | Low-region chip select, active low |
| rfsh_cs3_n | output | 1 | Refresh strobe in PSRAM mode, otherwise mid-range select three, active low |
| bus_ready | output | 1 | One-cycle completion of the processor bus cycle |
| precharge | output | 1 | High during the precharge gap |

## Verification
In PSRAM mode off, the bench sweeps every wait-state count against both ready settings, several ready delays and three address regions. This shows whether the cycle length follows the wait count, whether it follows the ready delay, and which select each region drives. In PSRAM mode on, refresh strobes are timed without traffic, after reload writes below and at the floor of 18, and against an access placed just before a refresh falls due. This tells the timer period, reload-on-issue and the refresh deferral apart. A request raised on the first cycle of a refresh checks the stall. Control words with wrong wait or ready fields confirm that PSRAM mode stays off.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ACC  = 3'd1,
    SQ_DONE = 3'd2,
    SQ_PRE  = 3'd3,
    SQ_RFSH = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic       en;
    logic       ign_rdy;
    logic [1:0] waits;
  } lmem_cfg_t;

  // control word field positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_WAIT_LSB = 1;
  localparam int CTL_IGN_BIT  = 3;

  // wait count PSRAM mode demands
  localparam logic [1:0] PSRAM_WAITS = 2'b01;

endpackage

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
  import psram_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int MIN_RELOAD = 18,
  parameter int RELOAD_RST = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  logic [CNT_W-1:0] wdata,
  output lmem_cfg_t        cfg,
  output logic [CNT_W-1:0] reload
);

  localparam logic [CNT_W-1:0] MIN_R = CNT_W'(MIN_RELOAD);
  localparam logic [CNT_W-1:0] RST_R = CNT_W'(RELOAD_RST);

  logic en_ok;
  logic reload_ok;

  assign en_ok = wdata[CTL_EN_BIT] & wdata[CTL_IGN_BIT]
               & (wdata[CTL_WAIT_LSB +: 2] == PSRAM_WAITS);
  assign reload_ok = (wdata >= MIN_R);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      reload <= RST_R;
    end else if (we) begin
      if (!sel) begin
        cfg.waits   <= wdata[CTL_WAIT_LSB +: 2];
        cfg.ign_rdy <= wdata[CTL_IGN_BIT];
        cfg.en      <= en_ok;
      end else if (reload_ok) begin
        reload <= wdata;
      end
    end
  end

  // R3
  reload_floor_chk: assert property (@(posedge clk) disable iff (rst)
    reload >= MIN_R);

  // R2
  en_fields_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.en |-> (cfg.ign_rdy && cfg.waits == PSRAM_WAITS));

  // R3
  low_reload_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel && wdata < MIN_R) |=> $stable(reload));

endmodule

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  input  logic             issue,
  output logic             pending
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] start_val;

  assign start_val = reload - CNT_W'(1);
  assign pending   = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!en || issue) begin
      cnt <= start_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !issue && en) |=> (pending || !en));

  // R4
  reload_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && en) |=> !pending);

endmodule

// File: rtl/psram_bus_seq.sv
module psram_bus_seq
  import psram_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                PRE_CYC   = 2,
  parameter logic [ADDR_W-1:0] LOW_TOP   = 16'h4000,
  parameter logic [ADDR_W-1:0] MID3_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] MID3_TOP  = 16'hA000
) (
  input  logic              clk,
  input  logic              rst,
  input  lmem_cfg_t         cfg,
  input  logic              pending,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ext_ready,
  output logic              issue,
  output logic              lcs_n,
  output logic              cs3_n,
  output logic              bus_ready,
  output logic              precharge
);

  localparam int  MAXV    = (PRE_CYC > 4) ? PRE_CYC : 4;
  localparam int  CW      = $clog2(MAXV + 1);
  localparam bit  HAS_PRE = (PRE_CYC > 0);
  localparam logic [CW-1:0] PRE_LOAD = CW'((PRE_CYC > 0) ? PRE_CYC - 1 : 0);

  seq_state_e    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          hit_low, hit_low_n;
  logic          hit_mid, hit_mid_n;
  logic [CW-1:0] wait_ld;
  logic          in_cycle_n;

  assign wait_ld = CW'({1'b0, cfg.waits});

  always_comb begin
    state_n   = state;
    cnt_n     = cnt;
    hit_low_n = hit_low;
    hit_mid_n = hit_mid;
    issue     = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (pending) begin
          state_n = SQ_RFSH;
          cnt_n   = wait_ld + CW'(1);
          issue   = 1'b1;
        end else if (bus_req) begin
          state_n   = SQ_ACC;
          cnt_n     = wait_ld;
          hit_low_n = (bus_addr < LOW_TOP);
          hit_mid_n = (bus_addr >= MID3_BASE) && (bus_addr < MID3_TOP);
        end
      end
      SQ_ACC: begin
        if (cnt != '0) begin
          cnt_n = cnt - CW'(1);
        end else if (cfg.ign_rdy || ext_ready) begin
          state_n = SQ_DONE;
        end
      end
      SQ_DONE: begin
        if (HAS_PRE && cfg.en && hit_low) begin
          state_n = SQ_PRE;
          cnt_n   = PRE_LOAD;
        end else begin
          state_n = SQ_IDLE;
        end
      end
      SQ_PRE: begin
        if (cnt != '0) cnt_n = cnt - CW'(1);
        else           state_n = SQ_IDLE;
      end
      SQ_RFSH: begin
        if (cnt != '0) begin
          cnt_n = cnt - CW'(1);
        end else if (HAS_PRE) begin
          state_n = SQ_PRE;
          cnt_n   = PRE_LOAD;
        end else begin
          state_n = SQ_IDLE;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  assign in_cycle_n = (state_n == SQ_ACC) || (state_n == SQ_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      hit_low   <= 1'b0;
      hit_mid   <= 1'b0;
      lcs_n     <= 1'b1;
      cs3_n     <= 1'b1;
      bus_ready <= 1'b0;
      precharge <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      hit_low   <= hit_low_n;
      hit_mid   <= hit_mid_n;
      lcs_n     <= !(in_cycle_n && hit_low_n);
      cs3_n     <= cfg.en ? (state_n != SQ_RFSH) : !(in_cycle_n && hit_mid_n);
      bus_ready <= (state_n == SQ_DONE);
      precharge <= (state_n == SQ_PRE);
    end
  end

  // R5
  lcs_rfsh_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!lcs_n && !cs3_n));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  // R7
  pre_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    precharge |-> (lcs_n && cs3_n));

  // R7
  pre_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(precharge) |-> ($past(bus_ready) || $past(!cs3_n)));

  // R11
  issue_en_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> cfg.en);

  // R10
  rfsh_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.en && !cs3_n) |-> !bus_ready);

endmodule

// File: rtl/psram_refresh_ctl.sv
module psram_refresh_ctl
  import psram_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                CNT_W      = 10,
  parameter int                MIN_RELOAD = 18,
  parameter int                RELOAD_RST = 64,
  parameter int                PRE_CYC    = 2,
  parameter logic [ADDR_W-1:0] LOW_TOP    = 16'h4000,
  parameter logic [ADDR_W-1:0] MID3_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] MID3_TOP   = 16'hA000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ext_ready,
  output logic              lcs_n,
  output logic              rfsh_cs3_n,
  output logic              bus_ready,
  output logic              precharge
);

  lmem_cfg_t        cfg;
  logic [CNT_W-1:0] reload;
  logic             pending;
  logic             issue;

  psram_cfg_regs #(
    .CNT_W      (CNT_W),
    .MIN_RELOAD (MIN_RELOAD),
    .RELOAD_RST (RELOAD_RST)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .cfg    (cfg),
    .reload (reload)
  );

  psram_refresh_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg.en),
    .reload  (reload),
    .issue   (issue),
    .pending (pending)
  );

  psram_bus_seq #(
    .ADDR_W    (ADDR_W),
    .PRE_CYC   (PRE_CYC),
    .LOW_TOP   (LOW_TOP),
    .MID3_BASE (MID3_BASE),
    .MID3_TOP  (MID3_TOP)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .pending   (pending),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .ext_ready (ext_ready),
    .issue     (issue),
    .lcs_n     (lcs_n),
    .cs3_n     (rfsh_cs3_n),
    .bus_ready (bus_ready),
    .precharge (precharge)
  );

endmodule

// File: tb/sim_psram_refresh_ctl.sv
`timescale 1ns/1ps
module sim_psram_refresh_ctl;

  localparam int PRE = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [9:0]  cfg_wdata = '0;
  logic        bus_req = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        ext_ready = 1'b1;
  logic        lcs_n, rfsh_cs3_n, bus_ready, precharge;

  int checks = 0, fails = 0;
  int cyc = 0;
  int n_falls = 0, last_fall = 0, prev_fall = 0, overlap = 0;
  bit pin_prev = 1'b1;
  int wr_cyc = 0;

  localparam logic [15:0] A_LOW = 16'h0123, A_MID = 16'h8800, A_OTH = 16'hC000;

  psram_refresh_ctl #(.PRE_CYC(PRE)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .ext_ready(ext_ready),
    .lcs_n(lcs_n), .rfsh_cs3_n(rfsh_cs3_n), .bus_ready(bus_ready), .precharge(precharge)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rfsh_cs3_n && pin_prev) begin
      prev_fall = last_fall;
      last_fall = cyc;
      n_falls++;
    end
    pin_prev = rfsh_cs3_n;
    if (!rfsh_cs3_n && !lcs_n) overlap++;
  endtask

  task automatic wr(input bit sel, input logic [9:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic wait_fall(input int maxc, input string req);
    int n0 = n_falls;
    int k = 0;
    while (n_falls == n0 && k < maxc) begin step(); k++; end
    chk(n_falls != n0, req, "refresh strobe seen", n_falls - n0, 1);
  endtask

  task automatic no_falls(input int ncyc, input string req);
    int n0 = n_falls;
    repeat (ncyc) step();
    chk(n_falls == n0, req, "refresh strobes while mode off", n_falls - n0, 0);
  endtask

  // region: 0 low, 1 mid-range three, 2 other
  task automatic do_access(input logic [15:0] addr, input int waits, input bit ign,
                           input int dly, input int region, input bit on, input string req);
    int len = waits + 2 + (ign ? 0 : dly);
    int pre = (on && region == 0) ? PRE : 0;
    bus_addr = addr; bus_req = 1'b1; ext_ready = 1'b0;
    for (int i = 1; i <= len; i++) begin
      step();
      chk(lcs_n == !(region == 0), req, "lcs_n in cycle", lcs_n, !(region == 0));
      chk(rfsh_cs3_n == (on ? 1'b1 : !(region == 1)), req, "rfsh_cs3_n in cycle",
          rfsh_cs3_n, on ? 1 : !(region == 1));
      chk(bus_ready == (i == len), req, "bus_ready in cycle", bus_ready, i == len);
      ext_ready = (i >= waits + 1 + dly);
    end
    bus_req = 1'b0; ext_ready = 1'b1;
    for (int i = 0; i < pre; i++) begin
      step();
      chk(precharge && lcs_n && rfsh_cs3_n, "R7", "precharge gap", precharge, 1);
    end
    step();
    chk(!precharge, "R7", "no extra precharge", precharge, 0);
  endtask

  initial begin
    int f, first_low, rdy_cyc, early;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(lcs_n && rfsh_cs3_n, "R1", "selects high after reset", {lcs_n, rfsh_cs3_n}, 3);
    chk(!bus_ready && !precharge, "R1", "ready/precharge low", {bus_ready, precharge}, 0);
    no_falls(80, "R1");

    // R6 / R8 sweep with PSRAM mode off
    for (int w = 0; w < 4; w++)
      for (int ig = 0; ig < 2; ig++)
        for (int d = 0; d < 3; d++)
          for (int r = 0; r < 3; r++) begin
            wr(1'b0, {6'd0, ig[0], w[1:0], 1'b0});
            do_access(r == 0 ? A_LOW : (r == 1 ? A_MID : A_OTH), w, ig[0], d, r, 1'b0,
                      r == 1 ? "R8" : "R6");
          end

    // R2 control words that must not enable PSRAM mode
    wr(1'b0, 10'b0101);
    no_falls(80, "R2");
    do_access(A_MID, 2, 1'b0, 1, 1, 1'b0, "R2");
    wr(1'b0, 10'b0011);
    no_falls(80, "R2");
    wr(1'b0, 10'b1001);
    no_falls(80, "R2");

    // R4 first strobe and period
    wr(1'b1, 10'd20);
    wr(1'b0, 10'b1011);
    wait_fall(60, "R4");
    chk(last_fall == wr_cyc + 20, "R4", "first strobe cycle", last_fall, wr_cyc + 20);
    // R5 strobe shape
    chk(lcs_n && !bus_ready, "R5", "lcs high at strobe start", lcs_n, 1);
    for (int j = 0; j < 2; j++) begin
      step();
      chk(!rfsh_cs3_n && lcs_n && !precharge, "R5", "strobe held low", rfsh_cs3_n, 0);
    end
    for (int j = 0; j < PRE; j++) begin
      step();
      chk(rfsh_cs3_n && precharge && lcs_n, "R5", "precharge after refresh", precharge, 1);
    end
    step();
    chk(!precharge, "R5", "precharge ends", precharge, 0);
    wait_fall(60, "R4");
    chk(last_fall - prev_fall == 20, "R4", "strobe period", last_fall - prev_fall, 20);

    // R3 reload floor
    wr(1'b1, 10'd17);
    wait_fall(60, "R3"); wait_fall(60, "R3");
    chk(last_fall - prev_fall == 20, "R3", "reload 17 ignored", last_fall - prev_fall, 20);
    wr(1'b1, 10'd18);
    wait_fall(60, "R3"); wait_fall(60, "R3");
    chk(last_fall - prev_fall == 18, "R3", "reload 18 accepted", last_fall - prev_fall, 18);

    // R10 deferral of a due refresh behind an access
    wr(1'b1, 10'd40);
    wait_fall(60, "R10"); wait_fall(60, "R10");
    f = last_fall;
    while (cyc < f + 37) step();
    bus_addr = A_LOW; bus_req = 1'b1;
    first_low = -1; rdy_cyc = -1;
    for (int k = 0; k < 20 && rdy_cyc < 0; k++) begin
      step();
      if (!lcs_n && first_low < 0) first_low = cyc;
      if (bus_ready) rdy_cyc = cyc;
    end
    bus_req = 1'b0;
    chk(first_low == f + 38, "R10", "access taken before due refresh", first_low, f + 38);
    chk(rdy_cyc == f + 40, "R10", "access ready cycle", rdy_cyc, f + 40);
    wait_fall(60, "R10");
    chk(last_fall == f + 44, "R10", "refresh deferred past precharge", last_fall, f + 44);
    wait_fall(60, "R4");
    chk(last_fall - prev_fall == 40, "R4", "reload at issue", last_fall - prev_fall, 40);

    // R10 request raised during a refresh is stalled
    f = last_fall;
    bus_addr = A_LOW; bus_req = 1'b1;
    first_low = -1; rdy_cyc = -1; early = 0;
    for (int k = 0; k < 30 && rdy_cyc < 0; k++) begin
      step();
      if (!lcs_n && first_low < 0) first_low = cyc;
      if (bus_ready) rdy_cyc = cyc;
      if (cyc < f + 6 && (bus_ready || !lcs_n)) early++;
    end
    bus_req = 1'b0;
    chk(early == 0, "R10", "no ready or select during refresh", early, 0);
    chk(first_low == f + 6, "R10", "stalled access start", first_low, f + 6);
    chk(rdy_cyc == f + 8, "R10", "stalled access ready", rdy_cyc, f + 8);
    repeat (PRE + 1) step();

    // R9 mid-range access in PSRAM mode, R7 precharge after a low access
    do_access(A_MID, 1, 1'b1, 0, 1, 1'b1, "R9");
    do_access(A_OTH, 1, 1'b1, 0, 2, 1'b1, "R7");
    do_access(A_LOW, 1, 1'b1, 0, 0, 1'b1, "R7");
    chk(overlap == 0, "R5", "lcs_n low during strobe", overlap, 0);

    // R11 mode off again
    wr(1'b0, 10'd0);
    repeat (8) step();
    no_falls(120, "R11");
    do_access(A_MID, 0, 1'b0, 1, 1, 1'b0, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule